// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block takes an asynchronous serial line and turns each character on it into an 8-bit byte for a host. Each character is framed by one low start bit, eight data bits sent least significant bit first, and a high stop bit. The only timing reference is a strobe on the master clock. The strobe is high for a single clock cycle and repeats at sixteen times the baud rate. Every register runs on the master clock, and the strobe acts only as a clock enable.

The line first passes through a chain of flip-flops that synchronises it. A start is a high-to-low change on the synchronised line, observed from one strobe to the next. Halfway through the start bit the line is checked again, and if it has gone high the event is dropped as a glitch. Each data bit and the stop bit are then sampled one bit time apart, so every sample falls near the centre of its bit.

A finished byte goes into a one-character holding register and raises a ready flag. The host clears the flag with a one-cycle read pulse. Two more flags report a low stop bit and a byte that arrived before the previous one was read.

Top module: `oversampled_rx`

## Requirements
- R1: After reset, rx_data is 0x00 and rx_ready, frame_err and overrun are all 0.
- R2: The line passes through SYNC_STAGES (default 2) master-clock flip-flops before any receive logic uses it, and the receive state changes only in cycles where tick is high.
- R3: A start is recognised when the synchronised line is low on a tick after being high on the previous tick. On the 8th tick after that (OVS/2), the line is checked again; if it is high, the receiver returns to idle and no byte is delivered.
- R4: Data bits are sampled every OVS ticks after the start-bit check. The first bit received goes into rx_data[0] and the last into rx_data[7].
- R5: The stop bit is sampled OVS ticks after the last data bit. frame_err is 1 if it reads low and 0 if it reads high. The byte is delivered in either case.
- R6: rx_ready goes to 1 in the cycle after a character completes. It goes to 0 in the cycle after a one-cycle rd_strobe, unless a new character completes in that same cycle.
- R7: If a character completes while rx_ready is 1 and rd_strobe is low, overrun is set and rx_data takes the newer byte. rd_strobe clears overrun.
- R8: rx_data keeps its value except in the cycle after a character completes. A read does not change it.
- R9: A frame whose start bit begins right at the end of the previous stop bit, with no idle time between them, is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at OVS times the baud rate |
| rxd | input | 1 | Asynchronous serial input, high when idle |
| rd_strobe | input | 1 | Host read pulse; clears rx_ready and overrun |
| rx_data | output | DATA_W | Last received byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| frame_err | output | 1 | Stop bit of the last byte was low |
| overrun | output | 1 | A byte was overwritten before it was read |

## Verification
The hardest case to create is a start edge that turns out to be a glitch. The line has to drop for fewer than eight strobe periods and then return high, so that the receiver leaves idle and then goes back to it. The bench holds the line low for three strobes. It confirms that no byte appears, and then sends a real frame to show the receiver is back in idle. Overrun needs two frames with no read in between. It is sent back to back with no idle gap, which also covers R9.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/rxo_sync.sv
module rxo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxo_core.sv
module rxo_core
   import rxo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   localparam int CNT_W = $clog2(OVS),
   localparam int IDX_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   output logic              done,
   output logic              stop_ok,
   output logic [DATA_W-1:0] shreg,
   output rx_state_t         state,
   output logic [CNT_W-1:0]  cnt
);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS/2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

   logic             line_q;
   logic [IDX_W-1:0] idx;

   assign done    = tick && (state == ST_STOP) && (cnt == FULL_LAST);
   assign stop_ok = line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         line_q <= 1'b1;
      end else if (tick) begin
         line_q <= line;
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (line_q && !line) state <= ST_START;
            end
            ST_START: begin
               if (cnt == HALF_LAST) begin
                  cnt   <= '0;
                  idx   <= '0;
                  state <= line ? ST_IDLE : ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (cnt == FULL_LAST) begin
                  cnt   <= '0;
                  shreg <= {line, shreg[DATA_W-1:1]};
                  idx   <= idx + 1'b1;
                  if (idx == IDX_LAST) state <= ST_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt == FULL_LAST) begin
                  cnt   <= '0;
                  state <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxo_hold.sv
module rxo_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              stop_ok,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              frame_err,
   output logic              overrun
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_ready  <= 1'b0;
         frame_err <= 1'b0;
         overrun   <= 1'b0;
      end else if (done) begin
         rx_data   <= din;
         rx_ready  <= 1'b1;
         frame_err <= ~stop_ok;
         overrun   <= (rx_ready | overrun) & ~rd_strobe;
      end else if (rd_strobe) begin
         rx_ready <= 1'b0;
         overrun  <= 1'b0;
      end
   end
endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx
   import rxo_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(OVS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              frame_err,
   output logic              overrun
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("oversampled_rx: OVS must be even and at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("oversampled_rx: DATA_W must be positive");
   end

   logic              line_s;
   logic              done;
   logic              stop_ok;
   logic [DATA_W-1:0] shreg;
   rx_state_t         state;
   logic [CNT_W-1:0]  cnt;

   rxo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (line_s)
   );

   rxo_core #(.DATA_W(DATA_W), .OVS(OVS)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .line   (line_s),
      .done   (done),
      .stop_ok(stop_ok),
      .shreg  (shreg),
      .state  (state),
      .cnt    (cnt)
   );

   rxo_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .stop_ok  (stop_ok),
      .din      (shreg),
      .rd_strobe(rd_strobe),
      .rx_data  (rx_data),
      .rx_ready (rx_ready),
      .frame_err(frame_err),
      .overrun  (overrun)
   );
endmodule

// File: rtl/rxo_checker.sv
module rxo_checker
   import rxo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   localparam int CNT_W = $clog2(OVS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              rd_strobe,
   input logic              done,
   input logic              line,
   input rx_state_t         state,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ready,
   input logic              overrun
);
   assert_state_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(state));

   assert_glitch_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state == ST_START && cnt == CNT_W'(OVS/2 - 1) && line) |=> state == ST_IDLE);

   assert_ready_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_ready);

   assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !done) |=> !rx_ready);

   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_ready && !rd_strobe) |=> overrun);

   assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(rx_data));
endmodule

bind oversampled_rx rxo_checker #(.DATA_W(DATA_W), .OVS(OVS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .rd_strobe(rd_strobe),
   .done     (done),
   .line     (line_s),
   .state    (state),
   .cnt      (cnt),
   .rx_data  (rx_data),
   .rx_ready (rx_ready),
   .overrun  (overrun)
);

// File: tb/sim_oversampled_rx.sv
`timescale 1ns/1ps
module sim_oversampled_rx;
   localparam int TDIV = 4;
   localparam int BITC = 16 * TDIV;
   localparam int NV   = 6;
   // {stop bit, data byte}
   localparam logic [8:0] VEC [NV] = '{9'h1_A5, 9'h1_01, 9'h1_80, 9'h0_3C, 9'h1_FF, 9'h1_00};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic rxd = 1'b1;
   logic rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic rx_ready, frame_err, overrun;
   int total = 0;
   int bad = 0;
   int divc = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      divc <= (divc == TDIV-1) ? 0 : divc + 1;
      tick <= (divc == TDIV-1);
   end

   oversampled_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rd_strobe(rd_strobe),
      .rx_data(rx_data), .rx_ready(rx_ready), .frame_err(frame_err), .overrun(overrun)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(logic [7:0] b, logic stopb, int gap);
      rxd = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (BITC) @(negedge clk);
      end
      rxd = stopb;
      repeat (BITC) @(negedge clk);
      rxd = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   initial begin
      repeat (6) @(negedge clk);
      // R1 reset state
      check("R1 data", rx_data, 0);
      check("R1 ready", rx_ready, 0);
      check("R1 ferr", frame_err, 0);
      check("R1 ovr", overrun, 0);
      rst_n = 1'b1;
      repeat (BITC) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         send(VEC[v][7:0], VEC[v][8], 0);
         check("R4 data", rx_data, VEC[v][7:0]);
         check("R6 ready set", rx_ready, 1);
         check("R5 frame_err", frame_err, !VEC[v][8]);
         check("R7 no overrun", overrun, 0);
         do_read();
         check("R6 ready clear", rx_ready, 0);
         check("R8 data after read", rx_data, VEC[v][7:0]);
         repeat (2 * BITC) @(negedge clk);
      end

      // R3 glitch: low for three strobe periods only
      rxd = 1'b0;
      repeat (3 * TDIV) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * BITC) @(negedge clk);
      check("R3 glitch no ready", rx_ready, 0);
      check("R3 glitch data kept", rx_data, VEC[NV-1][7:0]);
      send(8'h5A, 1'b1, BITC);
      check("R3 recover data", rx_data, 8'h5A);
      check("R3 recover ready", rx_ready, 1);
      do_read();

      // R7 overrun and R9 back-to-back frames with no idle gap
      send(8'h12, 1'b1, 0);
      send(8'hC3, 1'b1, 0);
      check("R7 overrun set", overrun, 1);
      check("R7 newest data", rx_data, 8'hC3);
      check("R9 ready", rx_ready, 1);
      do_read();
      check("R7 overrun clear", overrun, 0);
      check("R6 ready clear2", rx_ready, 0);
      check("R8 data held", rx_data, 8'hC3);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule